// File: doc/BRIEF.md
# Single-Event Compare Bank

This block holds sixteen compare channels that watch one shared timebase. Each channel keeps a compare word and a two-bit mode. When the timer advances to a value equal to a channel's compare word, the channel emits a one-cycle event pulse, an interrupt pulse, or both, as its mode selects.

A channel can also be put into single-event operation. It then fires only while its bit in the enable word is set, and hardware clears that bit in the same cycle as the match. Later matches stay silent until software arms the channel again.

The enable word can only be written whole. A plain write that follows a software read can revive a channel that fired between the read and the write. To avoid this, two extra addresses set or clear only the bits written as 1, so software never needs a read-modify-write. Whenever a hardware clear and any software write meet on the same bit in the same cycle, the hardware clear takes effect.

Top module: `se_compare_unit`

## Requirements
- R1: After reset, every register reads 0, and `evtOut` and `irqOut` are 0.
- R2: If `timerTick` is 1 and `timerValue` equals channel n's compare word, and channel n is armed, then bit n of `evtOut` pulses for one cycle after that clock edge when mode bit 0 is 1. Bit n of `irqOut` pulses in the same cycle when mode bit 1 is 1. A channel is armed when its mode is not 00, and also its single-event bit is 0 or its enable bit is 1.
- R3: Mode 00 turns a channel off, and it then produces no event and no interrupt on an equal value.
- R4: While `timerTick` is 0, no channel produces an event or interrupt, whatever `timerValue` holds.
- R5: When a channel whose single-event bit is 1 fires, its enable bit reads 0 from the next cycle on.
- R6: A channel whose single-event bit is 1 and whose enable bit is 0 produces nothing on a match.
- R7: When a channel's single-event bit is 0, its enable bit neither gates its matches nor is changed by them.
- R8: A write to address 19 replaces the whole enable word. This can re-arm a channel that hardware has just cleared.
- R9: A write to address 20 sets the enable bits written as 1. A write to address 21 clears the enable bits written as 1. Other bits are untouched. Reads of addresses 19, 20 and 21 return the enable word.
- R10: If a single-event channel fires in the same cycle as a software write to the enable word, the channel's enable bit ends up 0.
- R11: The address map is as follows:
  - Compare words are at addresses 0 to 15, one per channel.
  - The mode of channel n is at address 16 + n/8, in bits [2*(n%8)+1 : 2*(n%8)]. Hardware never changes the mode.
  - Address 18 holds the single-event bits, with bit n for channel n.
  - Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Register address for reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `addr` |
| timerTick | input | 1 | Marks a cycle in which the timer has taken a new value |
| timerValue | input | 16 | Shared timer value |
| evtOut | output | 16 | Per-channel event pulses |
| irqOut | output | 16 | Per-channel interrupt pulses |

## Verification
A match is sampled at the clock edge that sees `timerTick`, and its pulses on `evtOut` and `irqOut` are valid for exactly the one cycle that follows. The bench therefore drives a tick on a falling edge and checks both vectors on the next falling edge. A register write takes effect at the same edge, while read data is combinational. Readbacks, including the enable word after a hardware clear, are set up on a falling edge and sampled one time unit later, which is one cycle after the write or match. In the cases where a write and a match fall in the same cycle, the expected values take every match from the state before the write. The hardware clear is applied after the write.

// File: rtl/se_cmp_pkg.sv
package se_cmp_pkg;

  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_EVT  = 2'b01,
    MODE_IRQ  = 2'b10,
    MODE_BOTH = 2'b11
  } cmpMode_e;

  // strobes from the address decoder to the register datapath
  typedef struct packed {
    logic             cmpWr;
    logic             modeWr;
    logic             selWr;
    logic             enLoad;
    logic             enSet;
    logic             enClr;
    logic [IDX_W-1:0] wrIdx;
    logic             rdCmp;
    logic             rdMode;
    logic             rdSel;
    logic             rdEn;
    logic [IDX_W-1:0] rdIdx;
  } regStrobe_t;

endpackage

// File: rtl/se_cmp_ctrl.sv
module se_cmp_ctrl
  import se_cmp_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strobe
);

  localparam int MODE_PER_REG = DATA_W / 2;
  localparam int MODE_REGS    = (NUM_CH + MODE_PER_REG - 1) / MODE_PER_REG;
  localparam logic [ADDR_W-1:0] CMP_END  = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_CH + MODE_REGS);
  localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(NUM_CH + MODE_REGS + 1);
  localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(NUM_CH + MODE_REGS + 2);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_CH + MODE_REGS + 3);

  logic             isCmp;
  logic             isMode;
  logic             isEnAny;
  logic [IDX_W-1:0] localIdx;

  always_comb begin
    isCmp    = (addr < CMP_END);
    isMode   = (addr >= CMP_END) && (addr < SEL_ADDR);
    isEnAny  = (addr == EN_ADDR) || (addr == SET_ADDR) || (addr == CLR_ADDR);
    localIdx = isCmp ? IDX_W'(addr) : IDX_W'(addr - CMP_END);

    strobe        = '0;
    strobe.wrIdx  = localIdx;
    strobe.rdIdx  = localIdx;
    strobe.rdCmp  = isCmp;
    strobe.rdMode = isMode;
    strobe.rdSel  = (addr == SEL_ADDR);
    strobe.rdEn   = isEnAny;
    strobe.cmpWr  = wrEn && isCmp;
    strobe.modeWr = wrEn && isMode;
    strobe.selWr  = wrEn && (addr == SEL_ADDR);
    strobe.enLoad = wrEn && (addr == EN_ADDR);
    strobe.enSet  = wrEn && (addr == SET_ADDR);
    strobe.enClr  = wrEn && (addr == CLR_ADDR);
  end

endmodule

// File: rtl/se_cmp_chan.sv
module se_cmp_chan
  import se_cmp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] cmpVal,
  input  logic [DATA_W-1:0] timerValue,
  input  logic              timerTick,
  input  logic [1:0]        mode,
  input  logic              singleSel,
  input  logic              armBit,
  output logic              hit,
  output logic              hwClr
);

  logic equalNow;
  logic armed;

  always_comb begin
    equalNow = timerTick && (timerValue == cmpVal);
    armed    = (cmpMode_e'(mode) != MODE_OFF) && (!singleSel || armBit);
    hit      = equalNow && armed;
    hwClr    = hit && singleSel;
  end

endmodule

// File: rtl/se_cmp_datapath.sv
module se_cmp_datapath
  import se_cmp_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              timerTick,
  input  logic [DATA_W-1:0] timerValue,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] evtOut,
  output logic [NUM_CH-1:0] irqOut,
  output logic [NUM_CH-1:0] enState,
  output logic [NUM_CH-1:0] selState
);

  localparam int MODE_PER_REG = DATA_W / 2;

  logic [DATA_W-1:0] cmpReg  [NUM_CH];
  logic [1:0]        modeReg [NUM_CH];
  logic [NUM_CH-1:0] selReg;
  logic [NUM_CH-1:0] enReg;
  logic [NUM_CH-1:0] enNext;
  logic [NUM_CH-1:0] hitVec;
  logic [NUM_CH-1:0] hwClrVec;
  logic [NUM_CH-1:0] wrBits;

  assign wrBits = wrData[NUM_CH-1:0];

  // one comparator per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    se_cmp_chan #(.DATA_W(DATA_W)) i_chan (
      .cmpVal    (cmpReg[ch]),
      .timerValue(timerValue),
      .timerTick (timerTick),
      .mode      (modeReg[ch]),
      .singleSel (selReg[ch]),
      .armBit    (enReg[ch]),
      .hit       (hitVec[ch]),
      .hwClr     (hwClrVec[ch])
    );
  end

  // compare words and modes: software only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        cmpReg[ch]  <= '0;
        modeReg[ch] <= 2'b00;
      end
    end else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (strobe.cmpWr && strobe.wrIdx == IDX_W'(ch))
          cmpReg[ch] <= wrData;
        if (strobe.modeWr && strobe.wrIdx == IDX_W'(ch / MODE_PER_REG))
          modeReg[ch] <= wrData[(ch % MODE_PER_REG)*2 +: 2];
      end
    end
  end

  // enable word: software load/set/clear first, hardware clear last
  always_comb begin
    enNext = enReg;
    if (strobe.enLoad) enNext = wrBits;
    if (strobe.enSet)  enNext = enNext | wrBits;
    if (strobe.enClr)  enNext = enNext & ~wrBits;
    enNext = enNext & ~hwClrVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      enReg  <= '0;
      evtOut <= '0;
      irqOut <= '0;
    end else begin
      if (strobe.selWr) selReg <= wrBits;
      enReg <= enNext;
      for (int ch = 0; ch < NUM_CH; ch++) begin
        evtOut[ch] <= hitVec[ch] && modeReg[ch][0];
        irqOut[ch] <= hitVec[ch] && modeReg[ch][1];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdCmp) begin
      for (int ch = 0; ch < NUM_CH; ch++)
        if (strobe.rdIdx == IDX_W'(ch)) rdData = cmpReg[ch];
    end
    if (strobe.rdMode) begin
      for (int ch = 0; ch < NUM_CH; ch++)
        if (strobe.rdIdx == IDX_W'(ch / MODE_PER_REG))
          rdData[(ch % MODE_PER_REG)*2 +: 2] = modeReg[ch];
    end
    if (strobe.rdSel) rdData[NUM_CH-1:0] = selReg;
    if (strobe.rdEn)  rdData[NUM_CH-1:0] = enReg;
  end

  assign enState  = enReg;
  assign selState = selReg;

endmodule

// File: rtl/se_compare_unit.sv
module se_compare_unit
  import se_cmp_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              timerTick,
  input  logic [DATA_W-1:0] timerValue,
  output logic [NUM_CH-1:0] evtOut,
  output logic [NUM_CH-1:0] irqOut
);

  regStrobe_t        strobe;
  logic [NUM_CH-1:0] enState;
  logic [NUM_CH-1:0] selState;

  se_cmp_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .strobe(strobe)
  );

  se_cmp_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .timerTick (timerTick),
    .timerValue(timerValue),
    .rdData    (rdData),
    .evtOut    (evtOut),
    .irqOut    (irqOut),
    .enState   (enState),
    .selState  (selState)
  );

endmodule

// File: rtl/se_cmp_checker.sv
module se_cmp_checker #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              timerTick,
  input logic [NUM_CH-1:0] evtOut,
  input logic [NUM_CH-1:0] irqOut,
  input logic [NUM_CH-1:0] enState,
  input logic [NUM_CH-1:0] selState
);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (evtOut == '0 && irqOut == '0 && enState == '0));

  p_evt_needs_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evtOut != '0) |-> $past(timerTick));

  p_irq_needs_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut != '0) |-> $past(timerTick));

  // R5 and R10: a fired single-event channel is disarmed at the same edge
  p_fired_disarmed_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((evtOut | irqOut) & $past(selState) & enState) == '0);

  p_disarmed_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((evtOut | irqOut) & $past(selState) & ~$past(enState)) == '0);

  p_arm_needs_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((enState & ~$past(enState)) != '0) |-> $past(wrEn));

endmodule

bind se_compare_unit se_cmp_checker #(.NUM_CH(NUM_CH)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .timerTick(timerTick),
  .evtOut   (evtOut),
  .irqOut   (irqOut),
  .enState  (enState),
  .selState (selState)
);

// File: tb/test_se_compare_unit.sv
module test_se_compare_unit;

  localparam logic [4:0] A_MODE0 = 5'd16;
  localparam logic [4:0] A_MODE1 = 5'd17;
  localparam logic [4:0] A_SEL   = 5'd18;
  localparam logic [4:0] A_EN    = 5'd19;
  localparam logic [4:0] A_SET   = 5'd20;
  localparam logic [4:0] A_CLR   = 5'd21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        timerTick = 1'b0;
  logic [15:0] timerValue = '0;
  logic [15:0] evtOut;
  logic [15:0] irqOut;

  int total = 0;
  int bad = 0;

  logic [15:0] cmpM [16];
  logic [1:0]  modeM [16];
  logic [15:0] selM;
  logic [15:0] enM;

  always #5 clk = ~clk;

  se_compare_unit #(.NUM_CH(16), .DATA_W(16), .ADDR_W(5)) i_se_compare_unit (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .timerTick(timerTick), .timerValue(timerValue),
    .evtOut(evtOut), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [4:0] a, input logic [15:0] d);
    if (a < 5'd16) cmpM[a[3:0]] = d;
    else if (a == A_MODE0) for (int i = 0; i < 8; i++) modeM[i] = d[2*i +: 2];
    else if (a == A_MODE1) for (int i = 0; i < 8; i++) modeM[i+8] = d[2*i +: 2];
    else if (a == A_SEL) selM = d;
    else if (a == A_EN) enM = d;
    else if (a == A_SET) enM = enM | d;
    else if (a == A_CLR) enM = enM & ~d;
  endtask

  function automatic logic [15:0] readExp(input logic [4:0] a);
    logic [15:0] v;
    v = '0;
    if (a < 5'd16) v = cmpM[a[3:0]];
    else if (a == A_MODE0) for (int i = 0; i < 8; i++) v[2*i +: 2] = modeM[i];
    else if (a == A_MODE1) for (int i = 0; i < 8; i++) v[2*i +: 2] = modeM[i+8];
    else if (a == A_SEL) v = selM;
    else if (a == A_EN || a == A_SET || a == A_CLR) v = enM;
    return v;
  endfunction

  // one clock: optional tick and optional write in the same cycle, pulses checked after
  task automatic cycle(input logic tk, input logic [15:0] tv, input logic we,
                       input logic [4:0] a, input logic [15:0] d, input string tag);
    logic [15:0] hitM, expEvt, expIrq, selOld;
    @(negedge clk);
    timerTick = tk; timerValue = tv; wrEn = we; addr = a; wrData = d;
    hitM = '0; expEvt = '0; expIrq = '0; selOld = selM;
    for (int ch = 0; ch < 16; ch++) begin
      if (tk && modeM[ch] != 2'b00 && cmpM[ch] == tv && (!selM[ch] || enM[ch])) begin
        hitM[ch]   = 1'b1;
        expEvt[ch] = modeM[ch][0];
        expIrq[ch] = modeM[ch][1];
      end
    end
    if (we) modelWrite(a, d);
    enM = enM & ~(hitM & selOld);
    @(negedge clk);
    timerTick = 1'b0; wrEn = 1'b0;
    check({tag, " evtOut"}, evtOut, expEvt);
    check({tag, " irqOut"}, irqOut, expIrq);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input string tag);
    cycle(1'b0, 16'h0000, 1'b1, a, d, tag);
  endtask

  task automatic tick(input logic [15:0] v, input string tag);
    cycle(1'b1, v, 1'b0, 5'd0, 16'h0000, tag);
  endtask

  task automatic readChk(input logic [4:0] a, input string tag);
    addr = a;
    #1;
    check(tag, rdData, readExp(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 16; i++) begin cmpM[i] = '0; modeM[i] = 2'b00; end
    selM = '0; enM = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 24; a++) readChk(5'(a), "R1 reset read");
    check("R1 evtOut at reset", evtOut, 16'h0000);
    check("R1 irqOut at reset", irqOut, 16'h0000);

    // setup: ch3 both, ch5 evt, ch6 irq, ch7 off, ch2 both, ch9 both
    wr(5'd3, 16'h0100, "R11 setup"); wr(5'd5, 16'h0100, "R11 setup");
    wr(5'd6, 16'h0100, "R11 setup"); wr(5'd7, 16'h0100, "R11 setup");
    wr(5'd2, 16'h0020, "R11 setup"); wr(5'd9, 16'h0020, "R11 setup");
    wr(A_MODE0, 16'h24F0, "R11 setup"); wr(A_MODE1, 16'h000C, "R11 setup");
    readChk(5'd3, "R11 cmp readback");
    readChk(A_MODE0, "R11 mode readback");

    tick(16'h0100, "R2 match");
    tick(16'h0101, "R2 no match");
    @(negedge clk); timerTick = 1'b1; timerValue = 16'h0100; @(negedge clk);
    timerTick = 1'b0;
    check("R2 literal evtOut", evtOut, 16'h0028);
    check("R2 literal irqOut", irqOut, 16'h0048);
    cycle(1'b0, 16'h0100, 1'b0, 5'd0, 16'h0, "R4 no tick");
    tick(16'h0100, "R3 ch7 off");

    // single-event: ch2 armed, ch9 selected but disarmed
    wr(A_SEL, 16'h0204, "R5 setup");
    wr(A_SET, 16'h0004, "R9 set");
    readChk(A_EN, "R9 set read");
    tick(16'h0020, "R5 fire");
    readChk(A_EN, "R5 enable cleared");
    check("R5 literal enable", rdData, 16'h0000);
    tick(16'h0020, "R6 disarmed");

    // R7 non-single channel unaffected by enable
    wr(A_EN, 16'h0000, "R7 setup");
    tick(16'h0100, "R7 fires"); tick(16'h0100, "R7 fires again");
    wr(A_SET, 16'h0008, "R7 set ch3");
    tick(16'h0100, "R7 fire with bit");
    readChk(A_EN, "R7 bit kept");
    wr(A_CLR, 16'h0008, "R9 clr");

    // R8 hazard with plain write
    wr(A_SET, 16'h0004, "R8 arm");
    readChk(A_EN, "R8 read before");
    tick(16'h0020, "R8 fire");
    wr(A_EN, 16'h0204, "R8 plain write");
    readChk(A_EN, "R8 re-armed");
    tick(16'h0020, "R8 both fire");

    // R9 aliases keep fired channel disarmed
    wr(A_SET, 16'h0004, "R9 arm");
    tick(16'h0020, "R9 fire");
    wr(A_SET, 16'h0200, "R9 set other");
    readChk(A_SET, "R9 alias read");
    check("R9 literal enable", rdData, 16'h0200);
    wr(A_CLR, 16'h0200, "R9 clear other");
    readChk(A_CLR, "R9 clear read");

    // R10 hardware clear wins
    wr(A_SET, 16'h0004, "R10 arm");
    cycle(1'b1, 16'h0020, 1'b1, A_SET, 16'h0004, "R10 set collide");
    readChk(A_EN, "R10 after set");
    wr(A_SET, 16'h0004, "R10 rearm");
    cycle(1'b1, 16'h0020, 1'b1, A_EN, 16'hFFFF, "R10 load collide");
    readChk(A_EN, "R10 after load");
    check("R10 literal enable", rdData, 16'hFFFB);

    readChk(A_MODE0, "R11 mode unchanged");
    readChk(A_MODE1, "R11 mode unchanged");
    readChk(5'd22, "R11 unmapped");

    // constrained random
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0, 1, 2: tick(16'($urandom % 8), "R2 rand tick");
        3: wr(5'($urandom % 16), 16'($urandom % 8), "R11 rand cmp");
        4: wr(($urandom % 2) ? A_MODE1 : A_MODE0, 16'($urandom), "R3 rand mode");
        5: wr(A_SEL, 16'($urandom), "R6 rand sel");
        6: wr(5'(19 + ($urandom % 3)), 16'($urandom), "R9 rand enable");
        default: cycle(1'b1, 16'($urandom % 8), 1'b1, 5'(19 + ($urandom % 3)),
                       16'($urandom), "R10 rand collide");
      endcase
      if (it % 10 == 0) begin
        readChk(A_EN, "R5 rand enable");
        readChk(A_SEL, "R11 rand sel");
        readChk(5'($urandom % 18), "R11 rand read");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule